// File: doc/BRIEF.md
# Variable-Length Displacement Decoder

This block turns a byte stream into signed 32-bit displacements. Each field describes its own length in the two top bits of its leading byte. A leading prefix of `0x` means one byte. A prefix of `10` means two bytes, and `11` means four bytes. Bytes arrive one per cycle over a valid/ready handshake, and the leading byte carries the most significant bits. The payload that follows the prefix is 7, 14 or 30 bits wide.

Once the final byte of a field has been accepted, the decoder extends the payload to 32 bits and raises a one-cycle result strobe. The strobe carries the value and the number of bytes the field used. While the strobe is high, input is refused, so the next field always starts cleanly on a new leading byte.

A mode input selects zero extension in place of sign extension. This lets the same decoder read count fields that use the same length prefix. The mode is taken from the cycle in which the leading byte is accepted.

Top module: `dispdec_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. An asynchronous reset (`rst_n` low) discards any partly assembled field.
- R2: A leading byte with bit 7 = 0 forms a complete one-byte field. The value is bits 6:0 of that byte, sign-extended from bit 6.
- R3: A leading byte with bits 7:6 = `10` starts a two-byte field. The first byte is the high byte of a 16-bit word, and the value is bits 13:0 of that word, sign-extended from bit 13.
- R4: A leading byte with bits 7:6 = `11` starts a four-byte field. The bytes form a 32-bit word, first byte highest, and the value is bits 29:0 of that word, sign-extended from bit 29.
- R5: `out_len` gives the byte count of the field as a binary number: 1, 2 or 4.
- R6: `out_valid` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the field's last byte.
- R7: `in_ready` is 0 in exactly the cycles in which `out_valid` is 1. No byte is accepted in those cycles.
- R8: When `unsigned_mode` is 1 in the cycle the leading byte is accepted, the payload is zero-extended instead of sign-extended.
- R9: Changes on `unsigned_mode` while the later bytes of a field are being accepted have no effect on that field's result.
- R10: A field that was interrupted by reset produces no result. The first byte accepted after reset is decoded as a leading byte.
- R11: Cycles with `in_valid` low neither advance nor disturb a field that is being assembled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unsigned_mode | input | 1 | 1 = zero-extend the payload; sampled with the leading byte |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | The decoder can accept a byte this cycle |
| in_data | input | 8 | Input byte stream, most significant byte of a field first |
| out_valid | output | 1 | One-cycle result strobe |
| out_disp | output | 32 | Extended displacement value |
| out_len | output | 3 | Bytes used by the field (1, 2 or 4) |

## Verification
The hardest situations to reach are the ones where the handshake and the field structure interact. One is a field interrupted by reset. Another is a change of mode in the middle of a four-byte field. A third is a new byte offered during the strobe cycle, when it must be refused. The stimulus keeps `in_valid` high straight through each strobe so that the refusal is exercised on every field. It deliberately flips `unsigned_mode` on the later bytes of some fields. It also resets the decoder right after the leading byte of a long field, then checks that the next byte decodes as a fresh one-byte field. Random fields with idle gaps inside them cover the rest, each compared with a behavioural model on every clock.

// File: rtl/dispdec_pkg.sv
package dispdec_pkg;

  localparam int BYTE_W    = 8;
  localparam int OUT_W     = 32;
  localparam int MAX_BYTES = 4;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_MORE  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

endpackage

// File: rtl/dispdec_prefix.sv
module dispdec_prefix #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic [BYTE_W-1:0] lead_byte,
  output logic [CNT_W-1:0]  lead_len
);

  always_comb begin
    unique case (lead_byte[BYTE_W-1 -: 2])
      2'b10:   lead_len = CNT_W'(2);
      2'b11:   lead_len = CNT_W'(4);
      default: lead_len = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/dispdec_ctrl.sv
module dispdec_ctrl
  import dispdec_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] lead_len,
  output logic             in_ready,
  output logic             take,
  output logic             take_first,
  output logic             take_last
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] left_q, left_d;

  assign in_ready   = (phase_q != PH_DONE);
  assign take       = in_valid && in_ready;
  assign take_first = take && (phase_q == PH_FIRST);
  assign take_last  = take && (((phase_q == PH_FIRST) && (lead_len == CNT_W'(1))) ||
                               ((phase_q == PH_MORE)  && (left_q == CNT_W'(1))));

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    unique case (phase_q)
      PH_FIRST: begin
        if (take) begin
          if (lead_len == CNT_W'(1)) begin
            phase_d = PH_DONE;
          end else begin
            phase_d = PH_MORE;
            left_d  = lead_len - CNT_W'(1);
          end
        end
      end
      PH_MORE: begin
        if (take) begin
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) phase_d = PH_DONE;
        end
      end
      PH_DONE: phase_d = PH_FIRST;
      default: phase_d = PH_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      left_q  <= '0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  // R11: an idle cycle leaves the remaining-byte count untouched
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(left_q));

  // R7: the refusing phase lasts a single cycle
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |=> (phase_q == PH_FIRST));

  // R5: never more bytes outstanding than the longest field minus its lead
  a_r5_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(MAX_BYTES - 1));

endmodule

// File: rtl/dispdec_gather.sv
module dispdec_gather #(
  parameter int BYTE_W = 8,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_first,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [OUT_W-1:0]  word_next
);

  logic [OUT_W-1:0] acc_q;

  assign word_next = take_first ? {{(OUT_W-BYTE_W){1'b0}}, byte_in}
                                : {acc_q[OUT_W-BYTE_W-1:0], byte_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= word_next;
    end
  end

  // R3: each later byte lands below the bytes already gathered
  a_r3_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_first) |=>
      (acc_q[BYTE_W-1:0] == $past(byte_in)) &&
      (acc_q[2*BYTE_W-1:BYTE_W] == $past(acc_q[BYTE_W-1:0])));

endmodule

// File: rtl/dispdec_extend.sv
module dispdec_extend #(
  parameter int BYTE_W = 8,
  parameter int OUT_W  = 32,
  parameter int CNT_W  = 3
) (
  input  logic [OUT_W-1:0] word,
  input  logic [CNT_W-1:0] len,
  input  logic             zext,
  output logic [OUT_W-1:0] value
);

  localparam int W1 = BYTE_W - 1;
  localparam int W2 = 2 * BYTE_W - 2;
  localparam int W4 = 4 * BYTE_W - 2;

  logic fill;

  always_comb begin
    fill  = 1'b0;
    value = '0;
    unique case (len)
      CNT_W'(1): begin
        fill  = !zext && word[W1-1];
        value = {{(OUT_W-W1){fill}}, word[W1-1:0]};
      end
      CNT_W'(2): begin
        fill  = !zext && word[W2-1];
        value = {{(OUT_W-W2){fill}}, word[W2-1:0]};
      end
      default: begin
        fill  = !zext && word[W4-1];
        value = {{(OUT_W-W4){fill}}, word[W4-1:0]};
      end
    endcase
  end

endmodule

// File: rtl/dispdec_top.sv
module dispdec_top
  import dispdec_pkg::*;
#(
  parameter int BYTE_W = dispdec_pkg::BYTE_W,
  parameter int OUT_W  = dispdec_pkg::OUT_W,
  parameter int CNT_W  = dispdec_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unsigned_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_disp,
  output logic [CNT_W-1:0]  out_len
);

  localparam int W1 = BYTE_W - 1;
  localparam int W4 = 4 * BYTE_W - 2;

  logic [CNT_W-1:0] lead_len;
  logic             take, take_first, take_last;
  logic [OUT_W-1:0] word_next, ext_value;

  logic [CNT_W-1:0] len_q, len_d, sel_len;
  logic             zext_q, zext_d, sel_zext;
  logic             valid_q, valid_d;
  logic [OUT_W-1:0] disp_q, disp_d;
  logic [CNT_W-1:0] olen_q, olen_d;
  logic             ozext_q, ozext_d;

  dispdec_prefix #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_prefix (
    .lead_byte (in_data),
    .lead_len  (lead_len)
  );

  dispdec_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .lead_len   (lead_len),
    .in_ready   (in_ready),
    .take       (take),
    .take_first (take_first),
    .take_last  (take_last)
  );

  dispdec_gather #(.BYTE_W(BYTE_W), .OUT_W(OUT_W)) i_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_first (take_first),
    .byte_in    (in_data),
    .word_next  (word_next)
  );

  assign sel_len  = take_first ? lead_len : len_q;
  assign sel_zext = take_first ? unsigned_mode : zext_q;

  dispdec_extend #(.BYTE_W(BYTE_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) i_extend (
    .word  (word_next),
    .len   (sel_len),
    .zext  (sel_zext),
    .value (ext_value)
  );

  always_comb begin
    len_d   = len_q;
    zext_d  = zext_q;
    valid_d = take_last;
    disp_d  = disp_q;
    olen_d  = olen_q;
    ozext_d = ozext_q;
    if (take_first) begin
      len_d  = lead_len;
      zext_d = unsigned_mode;
    end
    if (take_last) begin
      disp_d  = ext_value;
      olen_d  = sel_len;
      ozext_d = sel_zext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= CNT_W'(1);
      zext_q  <= 1'b0;
      valid_q <= 1'b0;
      disp_q  <= '0;
      olen_q  <= CNT_W'(1);
      ozext_q <= 1'b0;
    end else begin
      len_q   <= len_d;
      zext_q  <= zext_d;
      valid_q <= valid_d;
      disp_q  <= disp_d;
      olen_q  <= olen_d;
      ozext_q <= ozext_d;
    end
  end

  assign out_valid = valid_q;
  assign out_disp  = disp_q;
  assign out_len   = olen_q;

  // R7: no byte can enter while a result is being presented
  a_r7_refuse_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6: the strobe never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: only the three legal byte counts appear
  a_r5_len_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == CNT_W'(1) || out_len == CNT_W'(2) || out_len == CNT_W'(4)));

  // R2: a signed one-byte result fits in the 7-bit range
  a_r2_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == CNT_W'(1) && !ozext_q) |->
      ($countones(out_disp[OUT_W-1:W1-1]) == 0 ||
       $countones(out_disp[OUT_W-1:W1-1]) == OUT_W - W1 + 1));

  // R8: a zero-extended four-byte result has clear upper bits
  a_r8_zext_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == CNT_W'(4) && ozext_q) |-> (out_disp[OUT_W-1:W4] == '0));

  // R6: a strobe follows every accepted last byte
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> out_valid);

endmodule

// File: tb/test_dispdec_top.sv
module test_dispdec_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        unsigned_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic [31:0] out_disp;
  logic [2:0]  out_len;

  always #4 clk = ~clk;

  dispdec_top i_dispdec_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .unsigned_mode (unsigned_mode),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .out_valid     (out_valid),
    .out_disp      (out_disp),
    .out_len       (out_len)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // behavioural reference model state
  int          m_left = 0;
  logic [31:0] m_word = '0;
  int          m_len = 1;
  bit          m_uns = 1'b0, m_flip = 1'b0, m_gap = 1'b0, m_rst = 1'b0;
  bit          e_valid = 1'b0;
  logic [31:0] e_disp = '0;
  int          e_len = 1;
  string       e_tag = "R2";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input bit took, input logic [7:0] d, input bit m);
    int bits;
    longint val;
    e_valid = 1'b0;
    if (took) begin
      if (m_left == 0) begin
        m_len  = (d[7:6] == 2'b10) ? 2 : (d[7:6] == 2'b11) ? 4 : 1;
        m_word = {24'h0, d};
        m_uns  = m;
        m_flip = 1'b0;
        m_gap  = 1'b0;
        m_left = m_len - 1;
      end else begin
        m_word = {m_word[23:0], d};
        if (m != m_uns) m_flip = 1'b1;
        m_left--;
      end
      if (m_left == 0) begin
        bits = (m_len == 1) ? 7 : (m_len == 2) ? 14 : 30;
        val  = longint'(m_word) & ((64'd1 << bits) - 1);
        if (!m_uns && val[bits-1]) val = val - (64'sd1 <<< bits);
        e_disp  = val[31:0];
        e_len   = m_len;
        e_valid = 1'b1;
        if (m_flip)      e_tag = "R9";
        else if (m_rst)  e_tag = "R10";
        else if (m_gap)  e_tag = "R11";
        else if (m_uns)  e_tag = "R8";
        else if (m_len == 1) e_tag = "R2";
        else if (m_len == 2) e_tag = "R3";
        else e_tag = "R4";
        m_rst = 1'b0;
      end
    end else if (m_left != 0) begin
      m_gap = 1'b1;
    end
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "R6 out_valid", 32'(out_valid), 32'(e_valid));
    chk(in_ready == !e_valid, "R7 in_ready", 32'(in_ready), 32'(!e_valid));
    if (e_valid) begin
      chk(out_len == 3'(e_len), "R5 out_len", 32'(out_len), 32'(e_len));
      chk(out_disp == e_disp, {e_tag, " out_disp"}, out_disp, e_disp);
    end
  endtask

  // drive at the falling edge, then compare at the next falling edge
  task automatic step(input bit v, input logic [7:0] d, input bit m, output bit took);
    in_valid = v;
    in_data = d;
    unsigned_mode = m;
    took = v && in_ready;
    model(took, d, m);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic put_byte(input logic [7:0] d, input bit m);
    bit took;
    took = 1'b0;
    while (!took) step(1'b1, d, m, took);
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit m, input int gap, input bit flip);
    bit took;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) step(1'b0, 8'h5A, m, took);
      end
      put_byte(w[8*(n-1-i) +: 8], (flip && i > 0) ? !m : m);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    m_left = 0;
    e_valid = 1'b0;
    m_rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int sel, n;
    @(negedge clk);
    #1;
    do_reset();
    // R2: one-byte corners
    send(32'h3F, 1, 1'b0, 0, 1'b0);
    send(32'h40, 1, 1'b0, 0, 1'b0);
    send(32'h00, 1, 1'b0, 0, 1'b0);
    send(32'h7F, 1, 1'b0, 0, 1'b0);
    // R3: two-byte corners
    send(32'hBFFF, 2, 1'b0, 0, 1'b0);
    send(32'hA000, 2, 1'b0, 0, 1'b0);
    send(32'h8001, 2, 1'b0, 0, 1'b0);
    // R4: four-byte corners
    send(32'hDFFFFFFF, 4, 1'b0, 0, 1'b0);
    send(32'hE0000000, 4, 1'b0, 0, 1'b0);
    send(32'hC0000005, 4, 1'b0, 0, 1'b0);
    // R8: zero extension
    send(32'h40, 1, 1'b1, 0, 1'b0);
    send(32'hA000, 2, 1'b1, 0, 1'b0);
    send(32'hE0000000, 4, 1'b1, 0, 1'b0);
    // R11: idle gaps inside fields
    send(32'h9234, 2, 1'b0, 3, 1'b0);
    send(32'hC1234567, 4, 1'b0, 2, 1'b0);
    // R9: mode flips after the leading byte
    send(32'hF0000001, 4, 1'b0, 0, 1'b1);
    send(32'hF0000001, 4, 1'b1, 1, 1'b1);
    // R10: reset after a partial long field
    put_byte(8'hC5, 1'b0);
    do_reset();
    send(32'h05, 1, 1'b0, 0, 1'b0);
    send(32'h8ABC, 2, 1'b0, 0, 1'b0);
    // random fields
    for (int k = 0; k < 400; k++) begin
      r = $urandom;
      sel = $urandom_range(0, 3);
      n = (sel < 2) ? 1 : (sel == 2) ? 2 : 4;
      if (n == 1) r[7] = 1'b0;
      else if (n == 2) r[15:14] = 2'b10;
      else r[31:30] = 2'b11;
      send(r, n, 1'($urandom_range(0, 1)), $urandom_range(0, 2), ($urandom_range(0, 3) == 0));
    end
    in_valid = 1'b0;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule